// File: doc/BRIEF.md
# Supply and Thermal Fault Supervisor

This block decides, every cycle, which of four regulator channels may run. It watches three input supply rails and the die temperature, all delivered as sampled digital codes: supply codes in millivolts and the temperature code in degrees. A strobe marks the cycles in which those codes are fresh. Channels 0 and 1 are the two switching converters and share the switching input rail. Channel 2 is the first linear regulator, on its own rail. Channel 3 is the second linear regulator, also on its own rail.

Each rail has its own undervoltage lockout comparator, with its own threshold and hysteresis band. A lockout only stops the channels fed by that rail. An over-temperature comparator, also with hysteresis, stops every channel at once. When the die cools past the recovery point, the block issues a one-cycle soft-start request for each channel that the host has enabled and whose rail is healthy. A downstream ramp then restarts those channels from zero, so no channel simply resumes where it stopped.

Every lockout and the thermal flag start asserted out of reset. A live fault vector and a sticky fault vector are exposed. The sticky vector is cleared by a masked write strobe.

Top module: `rail_guard_sup`

## Requirements
- R1: While and right after reset, every bit of `fault_live` is 1 and every bit of `run_en`, `ss_pulse` and `fault_sticky` is 0, whatever the host enables are.
- R2: The lockout and thermal flags change only at a clock edge where `smp_valid` is high. With `smp_valid` low, the supply and temperature codes have no effect on `fault_live` or `run_en`.
- R3: The switching rail (`fault_live[0]`) locks when its code is below 2200. Once locked, it releases only when its code is above 2300. Codes from 2200 to 2300 keep the current state. While it is locked, `run_en[1:0]` are 0.
- R4: Linear rail A (`fault_live[1]`, feeding channel 2) and linear rail B (`fault_live[2]`, feeding channel 3) each lock when their code is below 1400. Each releases only when its code is above 1450.
- R5: A lockout on one rail clears the permits of that rail's channels only. Channels on healthy rails keep running.
- R6: The thermal flag (`fault_live[3]`) sets when the temperature code is 155 or more, and then all of `run_en` is 0. The flag clears only when the code is 130 or less.
- R7: `run_en[c]` is `host_en[c]` AND NOT (lockout of channel c's rail) AND NOT thermal. It follows `host_en` in the same cycle, with no clock edge in between.
- R8: After the edge where the thermal flag clears, `ss_pulse` is high for exactly one cycle. In that cycle it equals `host_en` at that edge, masked by the lockouts evaluated on the same sample. In every other cycle `ss_pulse` is 0, and clearing a lockout alone raises no pulse.
- R9: A bit of `fault_sticky` (same bit order as `fault_live`) sets at the edge where the matching live flag goes from 0 to 1, and then holds. The flags that are asserted out of reset do not set it.
- R10: A clock edge with `stat_clr_we` high clears the sticky bits selected by `stat_clr_mask`. If a fault entry occurs at the same edge, the entry wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | All sampled codes are fresh this cycle |
| vin_sw_mv | input | 12 | Switching input rail, millivolts |
| vin_la_mv | input | 12 | Linear rail A, millivolts |
| vin_lb_mv | input | 12 | Linear rail B, millivolts |
| die_temp | input | 9 | Die temperature code, degrees |
| host_en | input | 4 | Host enable per channel |
| stat_clr_we | input | 1 | Sticky-clear write strobe |
| stat_clr_mask | input | 4 | Sticky bits to clear |
| run_en | output | 4 | Run permit per channel |
| ss_pulse | output | 4 | One-cycle soft-start request per channel |
| fault_live | output | 4 | {thermal, rail B, rail A, switching rail} current flags |
| fault_sticky | output | 4 | Sticky fault record, same bit order |

## Verification
The bench builds the block with its default parameters. Those are 12-bit millivolt codes with a 2200/100 switching lockout and 1400/50 linear lockouts, plus a 9-bit temperature code with a 155 trip point and 25 degrees of hysteresis. With these integer codes the bench can land exactly on every band edge: one code under a threshold, exactly on the release point, and one code past it. Both edges of the thermal band (154/155 and 131/130) can be driven the same way, so each comparison's strictness is checked directly.

// File: rtl/rgs_pkg.sv
package rgs_pkg;

    localparam int NUM_RAILS = 3;
    localparam int NUM_CH    = 4;
    localparam int NUM_FLT   = NUM_RAILS + 1;

    localparam int DEF_VW      = 12;
    localparam int DEF_TW      = 9;
    localparam int DEF_SW_THR  = 2200;
    localparam int DEF_SW_HYS  = 100;
    localparam int DEF_LIN_THR = 1400;
    localparam int DEF_LIN_HYS = 50;
    localparam int DEF_T_TRIP  = 155;
    localparam int DEF_T_HYS   = 25;

    typedef enum logic [1:0] {
        RAIL_SW = 2'd0,
        RAIL_LA = 2'd1,
        RAIL_LB = 2'd2
    } rail_e;

    // Live fault vector: bit 3 thermal, bits 2:0 rail lockouts by rail index.
    typedef struct packed {
        logic                 therm;
        logic [NUM_RAILS-1:0] uvlo;
    } fault_t;

    // Which rail feeds a given channel.
    function automatic rail_e ch_rail(input int ch);
        rail_e r;
        case (ch)
            0, 1:    r = RAIL_SW;
            2:       r = RAIL_LA;
            default: r = RAIL_LB;
        endcase
        return r;
    endfunction

    // Per-channel block mask from per-rail lockout flags.
    function automatic logic [NUM_CH-1:0] ch_block(input logic [NUM_RAILS-1:0] uvlo);
        logic [NUM_CH-1:0] blk;
        for (int c = 0; c < NUM_CH; c++) begin
            blk[c] = uvlo[int'(ch_rail(c))];
        end
        return blk;
    endfunction

endpackage

// File: rtl/rgs_hyst_cmp.sv
module rgs_hyst_cmp #(
    parameter int W         = 12,
    parameter int THR       = 2200,
    parameter int HYS       = 100,
    parameter bit HIGH_TRIP = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         smp_valid,
    input  logic [W-1:0] code,
    output logic         flag_q,
    output logic         flag_d
);

    localparam int CLR_I = HIGH_TRIP ? (THR - HYS) : (THR + HYS);
    localparam logic [W:0] SET_PT = (W+1)'(THR);
    localparam logic [W:0] CLR_PT = (W+1)'(CLR_I);

    logic [W:0] code_x;
    logic       eval;

    assign code_x = {1'b0, code};

    generate
        if (HIGH_TRIP) begin : g_high
            // Trips at or above the set point, recovers at or below the lower point.
            always_comb begin
                if (flag_q) eval = (code_x > CLR_PT);
                else        eval = (code_x >= SET_PT);
            end
        end else begin : g_low
            // Trips below the set point, releases strictly above the upper point.
            always_comb begin
                if (flag_q) eval = !(code_x > CLR_PT);
                else        eval = (code_x < SET_PT);
            end
        end
    endgenerate

    assign flag_d = smp_valid ? eval : flag_q;

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b1;
        else     flag_q <= flag_d;
    end

endmodule

// File: rtl/rgs_sticky.sv
module rgs_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] live_q,
    input  logic [N-1:0] live_d,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] sticky
);

    logic [N-1:0] entry;
    logic [N-1:0] clr;

    assign entry = live_d & ~live_q;
    assign clr   = clr_we ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) sticky <= '0;
        else     sticky <= (sticky & ~clr) | entry;
    end

endmodule

// File: rtl/rgs_restart.sv
module rgs_restart #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           therm_q,
    input  logic           therm_d,
    input  logic [NCH-1:0] host_en,
    input  logic [NCH-1:0] blk_d,
    output logic [NCH-1:0] ss_pulse
);

    logic           recover;
    logic [NCH-1:0] ss_d;

    assign recover = therm_q & ~therm_d;

    always_comb begin
        ss_d = '0;
        if (recover) ss_d = host_en & ~blk_d;
    end

    always_ff @(posedge clk) begin
        if (rst) ss_pulse <= '0;
        else     ss_pulse <= ss_d;
    end

endmodule

// File: rtl/rail_guard_sup.sv
module rail_guard_sup
    import rgs_pkg::*;
#(
    parameter int VW      = DEF_VW,
    parameter int TW      = DEF_TW,
    parameter int SW_THR  = DEF_SW_THR,
    parameter int SW_HYS  = DEF_SW_HYS,
    parameter int LIN_THR = DEF_LIN_THR,
    parameter int LIN_HYS = DEF_LIN_HYS,
    parameter int T_TRIP  = DEF_T_TRIP,
    parameter int T_HYS   = DEF_T_HYS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               smp_valid,
    input  logic [VW-1:0]      vin_sw_mv,
    input  logic [VW-1:0]      vin_la_mv,
    input  logic [VW-1:0]      vin_lb_mv,
    input  logic [TW-1:0]      die_temp,
    input  logic [NUM_CH-1:0]  host_en,
    input  logic               stat_clr_we,
    input  logic [NUM_FLT-1:0] stat_clr_mask,
    output logic [NUM_CH-1:0]  run_en,
    output logic [NUM_CH-1:0]  ss_pulse,
    output logic [NUM_FLT-1:0] fault_live,
    output logic [NUM_FLT-1:0] fault_sticky
);

    logic [VW-1:0]        rail_code [NUM_RAILS];
    logic [NUM_RAILS-1:0] uvlo_q;
    logic [NUM_RAILS-1:0] uvlo_d;
    logic                 therm_q;
    logic                 therm_d;
    fault_t               flt_q;
    fault_t               flt_d;
    logic [NUM_CH-1:0]    blk_q;
    logic [NUM_CH-1:0]    blk_d;

    assign rail_code[int'(RAIL_SW)] = vin_sw_mv;
    assign rail_code[int'(RAIL_LA)] = vin_la_mv;
    assign rail_code[int'(RAIL_LB)] = vin_lb_mv;

    // One lockout comparator per rail; rail index picks its threshold set.
    generate
        for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
            if (r == int'(RAIL_SW)) begin : g_sw
                rgs_hyst_cmp #(
                    .W(VW), .THR(SW_THR), .HYS(SW_HYS), .HIGH_TRIP(1'b0)
                ) u_uvlo (
                    .clk(clk), .rst(rst), .smp_valid(smp_valid),
                    .code(rail_code[r]), .flag_q(uvlo_q[r]), .flag_d(uvlo_d[r])
                );
            end else begin : g_lin
                rgs_hyst_cmp #(
                    .W(VW), .THR(LIN_THR), .HYS(LIN_HYS), .HIGH_TRIP(1'b0)
                ) u_uvlo (
                    .clk(clk), .rst(rst), .smp_valid(smp_valid),
                    .code(rail_code[r]), .flag_q(uvlo_q[r]), .flag_d(uvlo_d[r])
                );
            end
        end
    endgenerate

    rgs_hyst_cmp #(
        .W(TW), .THR(T_TRIP), .HYS(T_HYS), .HIGH_TRIP(1'b1)
    ) u_otp (
        .clk(clk), .rst(rst), .smp_valid(smp_valid),
        .code(die_temp), .flag_q(therm_q), .flag_d(therm_d)
    );

    assign flt_q = '{therm: therm_q, uvlo: uvlo_q};
    assign flt_d = '{therm: therm_d, uvlo: uvlo_d};

    assign blk_q = ch_block(uvlo_q);
    assign blk_d = ch_block(uvlo_d);

    assign run_en     = host_en & ~blk_q & {NUM_CH{~therm_q}};
    assign fault_live = flt_q;

    rgs_restart #(
        .NCH(NUM_CH)
    ) u_restart (
        .clk(clk), .rst(rst),
        .therm_q(therm_q), .therm_d(therm_d),
        .host_en(host_en), .blk_d(blk_d),
        .ss_pulse(ss_pulse)
    );

    rgs_sticky #(
        .N(NUM_FLT)
    ) u_sticky (
        .clk(clk), .rst(rst),
        .live_q(flt_q), .live_d(flt_d),
        .clr_we(stat_clr_we), .clr_mask(stat_clr_mask),
        .sticky(fault_sticky)
    );

endmodule

// File: rtl/rgs_sup_chk.sv
module rgs_sup_chk
    import rgs_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               smp_valid,
    input logic [NUM_CH-1:0]  host_en,
    input logic [NUM_CH-1:0]  run_en,
    input logic [NUM_CH-1:0]  ss_pulse,
    input logic [NUM_FLT-1:0] fault_live,
    input logic [NUM_FLT-1:0] fault_sticky
);

    a_r7_permit_needs_host: assert property (@(posedge clk) disable iff (rst)
        (run_en & ~host_en) == '0);

    a_r6_therm_blocks_all: assert property (@(posedge clk) disable iff (rst)
        fault_live[3] |-> (run_en == '0));

    a_r3_sw_lock_blocks: assert property (@(posedge clk) disable iff (rst)
        fault_live[0] |-> (run_en[1:0] == 2'b00));

    a_r4_lin_a_lock_blocks: assert property (@(posedge clk) disable iff (rst)
        fault_live[1] |-> !run_en[2]);

    a_r4_lin_b_lock_blocks: assert property (@(posedge clk) disable iff (rst)
        fault_live[2] |-> !run_en[3]);

    a_r5_other_rail_runs: assert property (@(posedge clk) disable iff (rst)
        (fault_live[0] && !fault_live[1] && !fault_live[3] && host_en[2]) |-> run_en[2]);

    a_r2_hold_without_sample: assert property (@(posedge clk) disable iff (rst)
        !$past(smp_valid) |-> $stable(fault_live));

    a_r8_ss_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (ss_pulse != '0) |=> (ss_pulse == '0));

    a_r8_ss_after_therm_clear: assert property (@(posedge clk) disable iff (rst)
        (ss_pulse != '0) |-> ($past(fault_live[3]) && !fault_live[3]));

    generate
        for (genvar k = 0; k < NUM_FLT; k++) begin : g_stk
            a_r9_sticky_on_entry: assert property (@(posedge clk) disable iff (rst)
                $rose(fault_live[k]) |-> fault_sticky[k]);
        end
    endgenerate

endmodule

bind rail_guard_sup rgs_sup_chk u_chk (
    .clk(clk),
    .rst(rst),
    .smp_valid(smp_valid),
    .host_en(host_en),
    .run_en(run_en),
    .ss_pulse(ss_pulse),
    .fault_live(fault_live),
    .fault_sticky(fault_sticky)
);

// File: tb/rail_guard_sup_bench.sv
module rail_guard_sup_bench;

    localparam int CLK_P  = 10;
    localparam int NV     = 18;
    localparam int WD_CYC = 100000;

    logic        clk = 1'b0;
    logic        rst;
    logic        smp_valid;
    logic [11:0] vin_sw_mv, vin_la_mv, vin_lb_mv;
    logic [8:0]  die_temp;
    logic [3:0]  host_en;
    logic        stat_clr_we;
    logic [3:0]  stat_clr_mask;
    logic [3:0]  run_en, ss_pulse, fault_live, fault_sticky;

    int total = 0;
    int errs  = 0;

    always #(CLK_P/2) clk = ~clk;

    rail_guard_sup u_rail_guard_sup (
        .clk(clk), .rst(rst), .smp_valid(smp_valid),
        .vin_sw_mv(vin_sw_mv), .vin_la_mv(vin_la_mv), .vin_lb_mv(vin_lb_mv),
        .die_temp(die_temp), .host_en(host_en),
        .stat_clr_we(stat_clr_we), .stat_clr_mask(stat_clr_mask),
        .run_en(run_en), .ss_pulse(ss_pulse),
        .fault_live(fault_live), .fault_sticky(fault_sticky)
    );

    // {valid, sw, la, lb, temp, host, exp_live, exp_run, exp_ss}
    localparam logic [61:0] VEC [NV] = '{
        {1'b1, 12'd2400, 12'd1500, 12'd1500, 9'd25,  4'b1111, 4'b0000, 4'b1111, 4'b1111}, // R8 first clear
        {1'b1, 12'd2400, 12'd1500, 12'd1500, 9'd25,  4'b1111, 4'b0000, 4'b1111, 4'b0000},
        {1'b1, 12'd2150, 12'd1500, 12'd1500, 9'd25,  4'b1111, 4'b0001, 4'b1100, 4'b0000}, // R3 lock
        {1'b1, 12'd2250, 12'd1500, 12'd1500, 9'd25,  4'b1111, 4'b0001, 4'b1100, 4'b0000}, // R3 band
        {1'b1, 12'd2300, 12'd1500, 12'd1500, 9'd25,  4'b1111, 4'b0001, 4'b1100, 4'b0000}, // R3 edge
        {1'b1, 12'd2301, 12'd1500, 12'd1500, 9'd25,  4'b1111, 4'b0000, 4'b1111, 4'b0000}, // R3 release
        {1'b0, 12'd1000, 12'd1500, 12'd1500, 9'd25,  4'b1111, 4'b0000, 4'b1111, 4'b0000}, // R2 ignored
        {1'b1, 12'd2400, 12'd1399, 12'd1500, 9'd25,  4'b1111, 4'b0010, 4'b1011, 4'b0000}, // R4 R5
        {1'b1, 12'd2400, 12'd1450, 12'd1500, 9'd25,  4'b1111, 4'b0010, 4'b1011, 4'b0000}, // R4 edge
        {1'b1, 12'd2400, 12'd1451, 12'd1300, 9'd25,  4'b1111, 4'b0100, 4'b0111, 4'b0000}, // R4 R5
        {1'b1, 12'd2400, 12'd1500, 12'd1500, 9'd154, 4'b1111, 4'b0000, 4'b1111, 4'b0000}, // R6 below
        {1'b1, 12'd2400, 12'd1500, 12'd1500, 9'd155, 4'b1111, 4'b1000, 4'b0000, 4'b0000}, // R6 trip
        {1'b1, 12'd2400, 12'd1500, 12'd1500, 9'd131, 4'b1111, 4'b1000, 4'b0000, 4'b0000}, // R6 band
        {1'b1, 12'd2400, 12'd1300, 12'd1500, 9'd130, 4'b1110, 4'b0010, 4'b1010, 4'b1010}, // R8 masked
        {1'b1, 12'd2400, 12'd1500, 12'd1500, 9'd130, 4'b1111, 4'b0000, 4'b1111, 4'b0000}, // R8 no pulse
        {1'b1, 12'd2400, 12'd1500, 12'd1500, 9'd200, 4'b1111, 4'b1000, 4'b0000, 4'b0000}, // R6
        {1'b0, 12'd2400, 12'd1500, 12'd1500, 9'd20,  4'b1111, 4'b1000, 4'b0000, 4'b0000}, // R2 ignored
        {1'b1, 12'd2400, 12'd1500, 12'd1500, 9'd20,  4'b0101, 4'b0000, 4'b0101, 4'b0101}  // R8 host mask
    };

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic edge_then_settle();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_P * WD_CYC);
        errs++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", total - errs, total);
        $finish;
    end

    initial begin
        rst = 1'b1; smp_valid = 1'b0;
        vin_sw_mv = 12'd2400; vin_la_mv = 12'd1500; vin_lb_mv = 12'd1500;
        die_temp = 9'd25; host_en = 4'b1111;
        stat_clr_we = 1'b0; stat_clr_mask = 4'b0000;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 live in reset", fault_live, 4'b1111);
        chk("R1 run in reset", run_en, 4'b0000);
        @(negedge clk);
        rst = 1'b0;
        edge_then_settle();
        chk("R1 live after reset", fault_live, 4'b1111);
        chk("R1 run after reset", run_en, 4'b0000);
        chk("R1 ss after reset", ss_pulse, 4'b0000);
        chk("R1 sticky after reset", fault_sticky, 4'b0000);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            smp_valid = VEC[i][61];
            vin_sw_mv = VEC[i][60:49];
            vin_la_mv = VEC[i][48:37];
            vin_lb_mv = VEC[i][36:25];
            die_temp  = VEC[i][24:16];
            host_en   = VEC[i][15:12];
            edge_then_settle();
            chk($sformatf("R2/R3/R4/R5/R6 live row %0d", i), fault_live, VEC[i][11:8]);
            chk($sformatf("R7 run row %0d", i), run_en, VEC[i][7:4]);
            chk($sformatf("R8 ss row %0d", i), ss_pulse, VEC[i][3:0]);
        end

        // R9: every rail and thermal entered a fault during the table
        chk("R9 sticky record", fault_sticky, 4'b1111);

        // R10: masked clear
        @(negedge clk);
        smp_valid = 1'b0; host_en = 4'b1111;
        stat_clr_we = 1'b1; stat_clr_mask = 4'b0101;
        edge_then_settle();
        chk("R10 masked clear", fault_sticky, 4'b1010);

        // R10: entry at the same edge as a clear keeps the bit
        @(negedge clk);
        smp_valid = 1'b1; vin_sw_mv = 12'd2000;
        stat_clr_mask = 4'b0001;
        edge_then_settle();
        chk("R10 entry beats clear", fault_sticky, 4'b1011);
        chk("R3 lock again", fault_live, 4'b0001);

        @(negedge clk);
        smp_valid = 1'b0; stat_clr_mask = 4'b1111;
        edge_then_settle();
        chk("R10 clear all", fault_sticky, 4'b0000);
        @(negedge clk);
        stat_clr_we = 1'b0; stat_clr_mask = 4'b0000;

        // R7: permit follows host enable without a clock edge
        chk("R7 run before host change", run_en, 4'b1100);
        host_en = 4'b0100;
        #1;
        chk("R7 run follows host", run_en, 4'b0100);

        // R1: reset mid-run with host enables high
        @(negedge clk);
        host_en = 4'b1111; rst = 1'b1;
        repeat (2) edge_then_settle();
        chk("R1 live on re-reset", fault_live, 4'b1111);
        chk("R1 run on re-reset", run_en, 4'b0000);
        chk("R1 ss on re-reset", ss_pulse, 4'b0000);
        chk("R1 sticky on re-reset", fault_sticky, 4'b0000);

        // R9: flags asserted out of reset do not set the sticky record
        @(negedge clk);
        rst = 1'b0; smp_valid = 1'b1;
        vin_sw_mv = 12'd2400; vin_la_mv = 12'd1500; vin_lb_mv = 12'd1500;
        die_temp = 9'd200;
        edge_then_settle();
        chk("R6 hot after reset", fault_live, 4'b1000);
        chk("R9 no sticky from reset state", fault_sticky, 4'b0000);
        chk("R8 no pulse while hot", ss_pulse, 4'b0000);

        @(negedge clk);
        smp_valid = 1'b0;
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", total - errs, total);
        $finish;
    end

endmodule